// File: doc/BRIEF.md
# Two-Stage Spatial-Temporal Converter Voter

This block masks faults in the sampled output of three redundant analog-to-digital converters that are built in different ways. Two of the converters run at the base sample rate and each hands over one word per frame. The third runs ten times faster. Its ten words per frame are first collapsed into one word by a bitwise temporal vote. That word and the two base-rate words then go through a bitwise two-of-three spatial vote. The voted word leaves the block together with a flag that reports whether the three contributing words disagreed. The flag is what allows a fault to be detected as well as masked.

All data moves over valid/ready streams. An input word is taken on a clock edge where its valid and ready are both high. Each base-rate stream takes exactly one word per frame and then holds ready low until the frame has been voted. The fast stream takes ten words and then holds ready low. The output beat stays on the port until the consumer raises ready. While the beat waits, no new vote is made, and this back-pressure propagates to the inputs once their slots are full. If a base-rate word fails to arrive within the frame budget, the block flags a sticky timeout, repeats the last voted word and starts a fresh frame.

Top module: `st_voter`

## Requirements
- R1: After synchronous reset, out_vld and err_timeout are 0, and sd_rdy, sa_rdy and fs_rdy are 1.
- R2: Bit i of the temporal vote is 1 when at least 6 of the 10 fast words accepted in the frame have bit i set, and 0 otherwise, so a 5/5 split gives 0.
- R3: Each bit of out_word is the two-of-three majority of that bit across the sd word, the sa word and the temporal vote word.
- R4: When any one of the three contributing words differs from the other two, which agree, out_word equals the agreeing value, whatever number of bits differ.
- R5: out_mismatch is 1 on an output beat exactly when the three contributing words are not all equal. A single flipped bit in any one contributing word therefore sets it. out_mismatch is never 1 while out_vld is 0.
- R6: Once ten fast words and both base-rate words of a frame have been accepted, out_vld rises one clock later if the output is free. After its tenth word, fs_rdy stays 0 until the frame is voted.
- R7: While out_vld is 1 and out_rdy is 0, out_vld, out_word and out_mismatch hold their values.
- R8: If a base-rate word is still missing FRAME_CYC cycles after the frame's first accepted word, err_timeout becomes 1. An output beat then carries the previous out_word with out_mismatch 0, and the partial frame is discarded.
- R9: err_timeout stays 1 until reset, including across later frames that vote normally.
- R10: After a base-rate stream's word is accepted, its ready stays 0 until the frame is voted or discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sd_vld | input | 1 | Base-rate channel A word valid |
| sd_rdy | output | 1 | Base-rate channel A ready |
| sd_word | input | W | Base-rate channel A word |
| sa_vld | input | 1 | Base-rate channel B word valid |
| sa_rdy | output | 1 | Base-rate channel B ready |
| sa_word | input | W | Base-rate channel B word |
| fs_vld | input | 1 | Oversampled channel word valid |
| fs_rdy | output | 1 | Oversampled channel ready |
| fs_word | input | W | Oversampled channel word |
| out_vld | output | 1 | Voted word valid |
| out_rdy | input | 1 | Consumer ready for the voted word |
| out_word | output | W | Voted word |
| out_mismatch | output | 1 | Contributing words disagreed on this beat |
| err_timeout | output | 1 | Sticky missing-word error |

## Verification
The first frames have all three channels agree, so the flag must stay low and the output must follow the common word. Corruptions of one base-rate channel by a single bit and by several bits then show the difference between masking, where the output is right, and detection, where the flag is raised. A sweep flips each bit position in each channel in turn, to show that every single-bit fault is seen. Fast-channel frames with 4, 5 and 6 of 10 words flipped tell the temporal threshold apart from a plain OR or a simple two-word vote, and the 5/5 split pins the tie toward 0. A case where all three words differ tells a bitwise vote apart from word-level selection. A stalled consumer, a withheld base-rate word and a normal frame after the timeout exercise back-pressure, the repeat-on-timeout path and the sticky error.

// File: rtl/st_vote_pkg.sv
package st_vote_pkg;
  // Minimum number of set samples out of n that yields a 1 (strict majority).
  function automatic int maj_threshold(input int n);
    return n / 2 + 1;
  endfunction
endpackage

// File: rtl/st_prevote.sv
module st_prevote #(
  parameter int W   = 12,
  parameter int OVS = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         acc,
  input  logic [W-1:0] word,
  output logic [W-1:0] maj,
  output logic         full,
  output logic         empty
);
  localparam int CW  = $clog2(OVS + 1);
  localparam int THR = st_vote_pkg::maj_threshold(OVS);

  logic [CW-1:0] nw;

  always_ff @(posedge clk) begin
    if (rst || clr) nw <= '0;
    else if (acc)   nw <= nw + CW'(1);
  end

  assign full  = (nw == CW'(OVS));
  assign empty = (nw == '0);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [CW-1:0] ones;
    always_ff @(posedge clk) begin
      if (rst || clr)          ones <= '0;
      else if (acc && word[i]) ones <= ones + CW'(1);
    end
    assign maj[i] = (ones >= CW'(THR));
  end
endmodule

// File: rtl/st_maj3.sv
module st_maj3 #(
  parameter int W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y,
  output logic         mis
);
  assign y   = (a & b) | (a & c) | (b & c);
  assign mis = (a != b) || (b != c);
endmodule

// File: rtl/st_voter.sv
module st_voter #(
  parameter int W         = 12,
  parameter int OVS       = 10,
  parameter int FRAME_CYC = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sd_vld,
  output logic         sd_rdy,
  input  logic [W-1:0] sd_word,
  input  logic         sa_vld,
  output logic         sa_rdy,
  input  logic [W-1:0] sa_word,
  input  logic         fs_vld,
  output logic         fs_rdy,
  input  logic [W-1:0] fs_word,
  output logic         out_vld,
  input  logic         out_rdy,
  output logic [W-1:0] out_word,
  output logic         out_mismatch,
  output logic         err_timeout
);
  localparam int TW = $clog2(FRAME_CYC + 1);

  logic         have_sd, have_sa;
  logic [W-1:0] sd_q, sa_q;
  logic [W-1:0] pv_word, vy;
  logic         pv_full, pv_empty, vmis;
  logic [TW-1:0] timer;
  logic         open, tmo_due, out_free, vote_go, tmo_go, clr_frame;
  logic         sd_acc, sa_acc, fs_acc;

  assign open      = have_sd || have_sa || !pv_empty;
  assign tmo_due   = open && (timer == TW'(FRAME_CYC)) && !(have_sd && have_sa);
  assign out_free  = !out_vld || out_rdy;
  assign vote_go   = pv_full && have_sd && have_sa && out_free;
  assign tmo_go    = tmo_due && out_free;
  assign clr_frame = vote_go || tmo_go;

  assign sd_rdy = !have_sd && !tmo_due;
  assign sa_rdy = !have_sa && !tmo_due;
  assign fs_rdy = !pv_full && !tmo_due;
  assign sd_acc = sd_vld && sd_rdy;
  assign sa_acc = sa_vld && sa_rdy;
  assign fs_acc = fs_vld && fs_rdy;

  st_prevote #(.W(W), .OVS(OVS)) u_pre (
    .clk(clk), .rst(rst), .clr(clr_frame), .acc(fs_acc), .word(fs_word),
    .maj(pv_word), .full(pv_full), .empty(pv_empty)
  );

  st_maj3 #(.W(W)) u_maj (
    .a(sd_q), .b(sa_q), .c(pv_word), .y(vy), .mis(vmis)
  );

  // Base-rate slots: one word each per frame.
  always_ff @(posedge clk) begin
    if (rst || clr_frame) begin
      have_sd <= 1'b0;
      have_sa <= 1'b0;
    end else begin
      if (sd_acc) have_sd <= 1'b1;
      if (sa_acc) have_sa <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_q <= '0;
      sa_q <= '0;
    end else begin
      if (sd_acc) sd_q <= sd_word;
      if (sa_acc) sa_q <= sa_word;
    end
  end

  // Frame budget timer, runs from the first accepted word, saturates.
  always_ff @(posedge clk) begin
    if (rst || clr_frame)                       timer <= '0;
    else if (open && timer != TW'(FRAME_CYC))   timer <= timer + TW'(1);
  end

  // Output register stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld      <= 1'b0;
      out_word     <= '0;
      out_mismatch <= 1'b0;
      err_timeout  <= 1'b0;
    end else if (vote_go) begin
      out_vld      <= 1'b1;
      out_word     <= vy;
      out_mismatch <= vmis;
    end else if (tmo_go) begin
      out_vld      <= 1'b1;
      out_mismatch <= 1'b0;
      err_timeout  <= 1'b1;
    end else if (out_rdy) begin
      out_vld      <= 1'b0;
      out_mismatch <= 1'b0;
    end
  end
endmodule

// File: rtl/st_vote_chk.sv
module st_vote_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         sd_vld,
  input logic         sd_rdy,
  input logic         out_vld,
  input logic         out_rdy,
  input logic [W-1:0] out_word,
  input logic         out_mismatch,
  input logic         err_timeout
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_vld && !err_timeout));

  p_flag_needs_beat_r5: assert property (@(posedge clk) disable iff (rst)
    out_mismatch |-> out_vld);

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_word) && $stable(out_mismatch)));

  p_repeat_on_timeout_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(err_timeout) |-> (out_vld && !out_mismatch && out_word == $past(out_word)));

  p_sticky_err_r9: assert property (@(posedge clk) disable iff (rst)
    err_timeout |=> err_timeout);

  p_one_slow_word_r10: assert property (@(posedge clk) disable iff (rst)
    (sd_vld && sd_rdy) |=> !sd_rdy);
endmodule

bind st_voter st_vote_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .sd_vld(sd_vld), .sd_rdy(sd_rdy),
  .out_vld(out_vld), .out_rdy(out_rdy), .out_word(out_word),
  .out_mismatch(out_mismatch), .err_timeout(err_timeout)
);

// File: tb/test_st_voter.sv
`timescale 1ns/1ps
module test_st_voter;
  localparam int W = 12;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sd_vld = 1'b0, sa_vld = 1'b0, fs_vld = 1'b0, out_rdy = 1'b1;
  logic [W-1:0] sd_word = '0, sa_word = '0, fs_word = '0;
  logic sd_rdy, sa_rdy, fs_rdy, out_vld, out_mismatch, err_timeout;
  logic [W-1:0] out_word;

  always #10 clk = ~clk;

  st_voter i_st_voter (
    .clk(clk), .rst(rst),
    .sd_vld(sd_vld), .sd_rdy(sd_rdy), .sd_word(sd_word),
    .sa_vld(sa_vld), .sa_rdy(sa_rdy), .sa_word(sa_word),
    .fs_vld(fs_vld), .fs_rdy(fs_rdy), .fs_word(fs_word),
    .out_vld(out_vld), .out_rdy(out_rdy), .out_word(out_word),
    .out_mismatch(out_mismatch), .err_timeout(err_timeout)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [W-1:0] exp_w[$];
  logic         exp_m[$];
  string        exp_r[$];
  logic [W-1:0] last_exp = '0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // Monitor: compare each accepted output beat against the scoreboard.
  always @(negedge clk) begin
    if (!rst && out_vld && out_rdy) begin
      if (exp_w.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6 unexpected beat actual=%0h expected=none", out_word);
      end else begin
        logic [W-1:0] ew; logic em; string er;
        ew = exp_w.pop_front(); em = exp_m.pop_front(); er = exp_r.pop_front();
        chk(er, {19'd0, out_mismatch, out_word}, {19'd0, em, ew});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [W-1:0] maj3(input logic [W-1:0] a, b, c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic send_sd(input logic [W-1:0] w);
    @(posedge clk); #1; sd_vld = 1'b1; sd_word = w;
    do @(negedge clk); while (!sd_rdy);
    @(posedge clk); #1; sd_vld = 1'b0;
  endtask

  task automatic send_sa(input logic [W-1:0] w);
    @(posedge clk); #1; sa_vld = 1'b1; sa_word = w;
    do @(negedge clk); while (!sa_rdy);
    @(posedge clk); #1; sa_vld = 1'b0;
  endtask

  // Ten fast words: the first nflip are f^m, the rest f.
  task automatic send_fast(input logic [W-1:0] f, m, input int nflip);
    for (int k = 0; k < N; k++) begin
      @(posedge clk); #1; fs_vld = 1'b1; fs_word = (k < nflip) ? (f ^ m) : f;
      do @(negedge clk); while (!fs_rdy);
    end
    @(posedge clk); #1; fs_vld = 1'b0;
  endtask

  function automatic logic [W-1:0] temporal(input logic [W-1:0] f, m, input int nflip);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      int ones;
      ones = 0;
      for (int k = 0; k < N; k++) ones += (k < nflip) ? int'(f[i] ^ m[i]) : int'(f[i]);
      r[i] = (ones >= 6);
    end
    return r;
  endfunction

  task automatic expect_vote(input string r, input logic [W-1:0] a, b, f, m, input int nflip);
    logic [W-1:0] pv;
    pv = temporal(f, m, nflip);
    exp_w.push_back(maj3(a, b, pv));
    exp_m.push_back(!((a == b) && (b == pv)));
    exp_r.push_back(r);
    last_exp = maj3(a, b, pv);
  endtask

  task automatic frame(input string r, input logic [W-1:0] a, b, f, m, input int nflip);
    expect_vote(r, a, b, f, m, nflip);
    send_sd(a);
    send_sa(b);
    send_fast(f, m, nflip);
  endtask

  task automatic drain();
    while (exp_w.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] held;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 out_vld", out_vld, 0);
    chk("R1 err_timeout", err_timeout, 0);
    chk("R1 ready", {sd_rdy, sa_rdy, fs_rdy}, 3'b111);

    // R3: all agree; R6: valid one clock after the last word
    frame("R3 agree", 12'h5A3, 12'h5A3, 12'h5A3, 12'h000, 0);
    @(negedge clk); chk("R6 not yet valid", out_vld, 0);
    @(negedge clk); chk("R6 valid next clock", out_vld, 1);
    drain();

    // R4/R5: one base-rate channel wrong by one bit, then by several bits
    frame("R4 sd one bit", 12'h5A3 ^ 12'h010, 12'h5A3, 12'h5A3, 12'h000, 0);
    frame("R4 sa many bits", 12'h3C1, 12'h3C1 ^ 12'hF0F, 12'h3C1, 12'h000, 0);
    // R3: all three differ, bitwise vote
    frame("R3 all differ", 12'h0F0, 12'h0CC, 12'h0AA, 12'h000, 0);
    // R2: temporal threshold 4/10, 5/10 tie, 6/10
    frame("R2 four flipped", 12'h7E8, 12'h7E8, 12'h7E8, 12'h008, 4);
    frame("R2 tie to zero", 12'h7E8, 12'h7E8, 12'h7E8, 12'h008, 5);
    frame("R2 six set", 12'h7E8, 12'h7E8, 12'h7E8, 12'h001, 6);
    drain();

    // R5: every single-bit fault in every channel is flagged
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] bm;
      bm = 12'(1) << i;
      frame("R5 sd bit", 12'hA5C ^ bm, 12'hA5C, 12'hA5C, 12'h000, 0);
      frame("R5 sa bit", 12'hA5C, 12'hA5C ^ bm, 12'hA5C, 12'h000, 0);
      frame("R5 fast bit", 12'hA5C, 12'hA5C, 12'hA5C, bm, 10);
    end
    drain();

    // R10: base-rate ready drops after its word
    expect_vote("R10 frame", 12'h123, 12'h123, 12'h123, 12'h000, 0);
    send_sd(12'h123);
    @(negedge clk); chk("R10 sd_rdy low", sd_rdy, 0);
    send_sa(12'h123);
    @(negedge clk); chk("R10 sa_rdy low", sa_rdy, 0);
    send_fast(12'h123, 12'h000, 0);
    drain();

    // R6/R7: consumer stalls
    @(posedge clk); #1; out_rdy = 1'b0;
    frame("R7 first", 12'h111, 12'h111, 12'h111, 12'h000, 0);
    frame("R7 second", 12'h222, 12'h222, 12'h202, 12'h000, 0);
    @(negedge clk);
    chk("R6 fs_rdy low while full", fs_rdy, 0);
    held = out_word;
    repeat (5) @(negedge clk);
    chk("R7 still valid", out_vld, 1);
    chk("R7 word held", out_word, held);
    @(posedge clk); #1; out_rdy = 1'b1;
    drain();

    // R8: missing sa word
    exp_w.push_back(last_exp); exp_m.push_back(1'b0); exp_r.push_back("R8 repeat");
    send_sd(12'h9F0);
    send_fast(12'h9F0, 12'h000, 0);
    drain();
    chk("R8 err_timeout", err_timeout, 1);

    // R9: sticky across a good frame
    frame("R9 good frame", 12'h456, 12'h456, 12'h456, 12'h000, 0);
    drain();
    chk("R9 err sticky", err_timeout, 1);

    // R1: reset clears the error
    @(posedge clk); #1; rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk("R1 err cleared", err_timeout, 0);
    chk("R1 out_vld cleared", out_vld, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule